// File: doc/BRIEF.md
# Display AUX transaction controller

This block runs a single request/reply exchange on a display auxiliary channel under software control. Software fills a five-word data buffer with a four-byte request header and up to sixteen payload bytes, programs the number of bytes to send, and sets the busy bit in the control word. The controller streams the bytes out on a byte-serial transmit port, then waits for a reply frame on the byte-serial receive port, bounded by a selectable timeout.

When the exchange ends, the controller performs three updates. It writes the reply bytes back into the same buffer, replaces the byte count with the reply length and raises sticky status flags. Software clears those flags by writing ones. Sync pulse settings and a routing select are held in the control word and brought out as plain outputs for the physical layer, which lies outside this block.

The header layout is as follows:
- Byte 0 carries the command in its upper nibble and address bits 19:16 in its lower nibble.
- Bytes 1 and 2 carry the rest of the address.
- Byte 3 is the operation length minus one.

Top module: `aux_xact_ctrl`

## Requirements
- R1: Control word (address 0) bits are: [31] busy, [30] done, [29] timeout flag, [28] receive-error flag, [27] interrupt enable, [26] routing select, [25:24] timeout select, [20:16] byte count, [9:5] fast-wake sync raw, [4:0] standard sync raw. All other bits read 0. Writing 1 to bit 31 while idle starts a transaction that sends min(count,20) bytes on tx_data. tx_sop marks the first byte and tx_eop the last. A byte is held until tx_ready.
- R2: Data words sit at addresses 1 to 5. Byte k of the message is bits [31-8*(k%4) -: 8] of word k/4, so the first word's bits 31:24 go first.
- R3: While busy is set, writes to the control word and to the data words have no effect.
- R4: Every transaction end clears busy and sets done. Writing 1 to bit 30, 29 or 28 clears that flag.
- R5: Timeout select 0/1/2/3 gives 400/600/800/LONG_US microseconds. Counting uses CLK_PER_US clocks per microsecond and starts after the last request byte. If no reply start arrives in time, the transaction ends with the timeout flag set and count 0.
- R6: In the wait phase, a beat with rx_sop starts the reply. Reply bytes are stored in the R2 order from word 0 bits 31:24. At rx_eop the count field becomes the number of reply bytes, including the header byte. Unwritten buffer bytes keep their contents.
- R7: Reply bytes past the seventeenth are dropped, the count reports 17 and the receive-error flag is set.
- R8: A reply beat with rx_err set makes the transaction end with the receive-error flag set.
- R9: irq is high exactly when interrupt enable and done are both set.
- R10: sync_pulses and fw_sync_pulses equal the raw fields plus one. route_sel follows bit 26.
- R11: After reset the control word and data words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1..5 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Link accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First request byte |
| tx_eop | output | 1 | Last request byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sop | input | 1 | First reply byte |
| rx_eop | input | 1 | Last reply byte |
| rx_err | input | 1 | Receive path error on this beat |
| irq | output | 1 | Done interrupt |
| route_sel | output | 1 | Alternate routing select |
| sync_pulses | output | 6 | Effective standard sync pulse count |
| fw_sync_pulses | output | 6 | Effective fast-wake sync pulse count |

## Verification
A wrong transmit index or lane computation shows on tx_data in the same cycle as the faulty handshake. A broken capture index corrupts a data word, and this is visible on the first read after done. A timer that counts the wrong limit moves the busy-to-idle edge by whole microsecond multiples, and the bench measures this in cycles against the selected limit. Status or freeze faults appear on the next control read, and interrupt faults appear on irq one cycle after the end edge.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
  localparam int BUF_WORDS = 5;
  localparam int MSG_MAX   = 4 * BUF_WORDS;
  localparam int RPL_MAX   = 17;
  localparam int CNT_W     = 5;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT, S_RECV} xact_st_t;
  typedef logic [BUF_WORDS-1:0][31:0] dbuf_t;

  // bit offset of byte k inside its word: first byte in the top lane
  function automatic int lane_lsb(input logic [CNT_W-1:0] k);
    return 8 * (3 - int'(k[1:0]));
  endfunction

  function automatic logic [7:0] buf_byte(input dbuf_t b, input logic [CNT_W-1:0] k);
    return b[k[4:2]][lane_lsb(k) +: 8];
  endfunction

  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] n);
    return (n > CNT_W'(MSG_MAX)) ? CNT_W'(MSG_MAX) : n;
  endfunction

  function automatic int unsigned limit_us(input logic [1:0] sel, input int unsigned long_us);
    case (sel)
      2'd0:    return 400;
      2'd1:    return 600;
      2'd2:    return 800;
      default: return long_us;
    endcase
  endfunction

  function automatic logic [5:0] eff_pulses(input logic [4:0] raw);
    return {1'b0, raw} + 6'd1;
  endfunction
endpackage

// File: rtl/aux_timeout_timer.sv
module aux_timeout_timer
  import aux_xact_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int LONG_US    = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int PRE_W = $clog2(CLK_PER_US + 1);
  localparam int MAXUS = (LONG_US > 800) ? LONG_US : 800;
  localparam int US_W  = $clog2(MAXUS + 1);

  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us;
  logic [US_W-1:0]  lim_m1;
  logic             tick;

  assign lim_m1 = US_W'(limit_us(sel, LONG_US) - 1);
  assign tick   = run && (pre == PRE_W'(CLK_PER_US - 1));
  assign expire = tick && (us == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      us  <= '0;
    end else if (!run) begin
      pre <= '0;
      us  <= '0;
    end else if (tick) begin
      pre <= '0;
      us  <= us + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R5: the microsecond count never passes the selected limit
  p_us_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> us <= lim_m1);
endmodule

// File: rtl/aux_reply_capture.sv
module aux_reply_capture
  import aux_xact_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_sop,
  input  logic             rx_eop,
  input  logic             rx_err,
  output logic             started,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic [7:0]       wr_byte,
  output logic             fin,
  output logic [CNT_W-1:0] fin_len,
  output logic             fin_bad
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             bad;
  logic             beat;
  logic             room;

  assign started = arm && rx_valid && rx_sop;
  assign beat    = active && rx_valid;
  assign room    = cnt < CNT_W'(RPL_MAX);
  assign wr_en   = started || (beat && room);
  assign wr_idx  = started ? '0 : cnt;
  assign wr_byte = rx_data;
  assign fin     = (started || beat) && rx_eop;
  assign fin_len = started ? CNT_W'(1) : (room ? cnt + 1'b1 : CNT_W'(RPL_MAX));
  assign fin_bad = rx_err || (beat && (bad || !room));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bad    <= 1'b0;
    end else if (started) begin
      active <= !rx_eop;
      cnt    <= CNT_W'(1);
      bad    <= rx_err;
    end else if (beat) begin
      if (rx_eop) active <= 1'b0;
      if (room) cnt <= cnt + 1'b1;
      else      bad <= 1'b1;
      if (rx_err) bad <= 1'b1;
    end
  end

  // R7: stored reply length never exceeds the buffer's reply capacity
  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(RPL_MAX));
  // R7: a write strobe never targets a byte beyond the reply capacity
  p_wr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx < CNT_W'(RPL_MAX));
endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
  import aux_xact_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int LONG_US    = 1600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sop,
  input  logic        rx_eop,
  input  logic        rx_err,
  output logic        irq,
  output logic        route_sel,
  output logic [5:0]  sync_pulses,
  output logic [5:0]  fw_sync_pulses
);
  dbuf_t            dbuf;
  xact_st_t         st;
  logic             busy, done_f, tmo_f, rxe_f, irq_en, route_q;
  logic [1:0]       tsel;
  logic [CNT_W-1:0] msz, fw_raw, sy_raw, tx_idx, tx_n;

  logic             tmr_exp;
  logic             cap_start, cap_we, cap_fin, cap_bad;
  logic [CNT_W-1:0] cap_idx, cap_len;
  logic [7:0]       cap_byte;

  // named internal events
  logic ctl_ok, dat_ok, start_req, tx_fire, tx_last, end_tmo, xact_end;
  logic [CNT_W-1:0] start_n;

  assign ctl_ok    = reg_wr && (reg_addr == 3'd0) && !busy;
  assign dat_ok    = reg_wr && (reg_addr >= 3'd1) && (reg_addr <= 3'(BUF_WORDS)) && !busy;
  assign start_req = ctl_ok && reg_wdata[31];
  assign start_n   = clamp_len(reg_wdata[20:16]);
  assign tx_fire   = tx_valid && tx_ready;
  assign tx_last   = tx_fire && tx_eop;
  assign end_tmo   = (st == S_WAIT) && tmr_exp && !cap_start;
  assign xact_end  = end_tmo || cap_fin;

  assign tx_valid = (st == S_TX);
  assign tx_data  = buf_byte(dbuf, tx_idx);
  assign tx_sop   = tx_valid && (tx_idx == '0);
  assign tx_eop   = tx_valid && (tx_idx == tx_n - 1'b1);

  assign irq            = irq_en && done_f;
  assign route_sel      = route_q;
  assign sync_pulses    = eff_pulses(sy_raw);
  assign fw_sync_pulses = eff_pulses(fw_raw);

  aux_timeout_timer #(.CLK_PER_US(CLK_PER_US), .LONG_US(LONG_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == S_WAIT), .sel(tsel), .expire(tmr_exp)
  );

  aux_reply_capture u_cap (
    .clk(clk), .rst_n(rst_n), .arm(st == S_WAIT),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err),
    .started(cap_start), .wr_en(cap_we), .wr_idx(cap_idx), .wr_byte(cap_byte),
    .fin(cap_fin), .fin_len(cap_len), .fin_bad(cap_bad)
  );

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      busy   <= 1'b0;
      tx_idx <= '0;
      tx_n   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_req) begin
          busy   <= 1'b1;
          tx_idx <= '0;
          tx_n   <= start_n;
          st     <= (start_n == '0) ? S_WAIT : S_TX;
        end
        S_TX: if (tx_last) st <= S_WAIT;
              else if (tx_fire) tx_idx <= tx_idx + 1'b1;
        S_WAIT: if (xact_end) st <= S_IDLE;
                else if (cap_start) st <= S_RECV;
        default: if (cap_fin) st <= S_IDLE;
      endcase
      if (xact_end) busy <= 1'b0;
    end
  end

  // control word and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0; tmo_f <= 1'b0; rxe_f <= 1'b0;
      irq_en <= 1'b0; route_q <= 1'b0; tsel <= '0;
      msz <= '0; fw_raw <= '0; sy_raw <= '0;
    end else if (ctl_ok) begin
      done_f  <= done_f & ~reg_wdata[30];
      tmo_f   <= tmo_f  & ~reg_wdata[29];
      rxe_f   <= rxe_f  & ~reg_wdata[28];
      irq_en  <= reg_wdata[27];
      route_q <= reg_wdata[26];
      tsel    <= reg_wdata[25:24];
      msz     <= reg_wdata[20:16];
      fw_raw  <= reg_wdata[9:5];
      sy_raw  <= reg_wdata[4:0];
    end else if (xact_end) begin
      done_f <= 1'b1;
      if (end_tmo) tmo_f <= 1'b1;
      if (cap_fin && cap_bad) rxe_f <= 1'b1;
      msz    <= end_tmo ? '0 : cap_len;
    end
  end

  // data buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbuf <= '0;
    end else begin
      if (dat_ok) dbuf[reg_addr - 3'd1] <= reg_wdata;
      if (cap_we) dbuf[cap_idx[4:2]][lane_lsb(cap_idx) +: 8] <= cap_byte;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 3'd0)
      reg_rdata = {busy, done_f, tmo_f, rxe_f, irq_en, route_q, tsel, 3'b000, msz,
                   6'b000000, fw_raw, sy_raw};
    else if (reg_addr <= 3'(BUF_WORDS))
      reg_rdata = dbuf[reg_addr - 3'd1];
  end

  // R3: a control write during busy leaves configuration untouched
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd0) |=>
      $stable({irq_en, route_q, tsel, fw_raw, sy_raw}));
  // R4: every busy-to-idle edge comes with done set
  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_f);
  // R1: transmit only during a transaction
  p_tx_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);
  // R1: a stalled byte is held unchanged
  p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R5: a timeout end reports an empty reply
  p_tmo_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_f) |-> msz == '0);
endmodule

// File: tb/aux_xact_ctrl_bench.sv
`timescale 1ns/1ps
module aux_xact_ctrl_bench;
  localparam int P    = 2;
  localparam int LONG = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_sop, tx_eop;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        irq, route_sel;
  logic [5:0]  sync_pulses, fw_sync_pulses;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  aux_xact_ctrl #(.CLK_PER_US(P), .LONG_US(LONG)) u_aux_xact_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err), .irq(irq), .route_sel(route_sel),
    .sync_pulses(sync_pulses), .fw_sync_pulses(fw_sync_pulses)
  );

  // transmit monitor
  logic [7:0] txb [64];
  logic       txs [64];
  logic       txe [64];
  int         txn = 0;
  always @(posedge clk) begin
    if (tx_valid && tx_ready && txn < 64) begin
      txb[txn] = tx_data;
      txs[txn] = tx_sop;
      txe[txn] = tx_eop;
      txn = txn + 1;
    end
  end

  // timeout table: select code and its microsecond limit
  localparam logic [1:0] T_SEL [4] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam int         T_US  [4] = '{400, 600, 800, LONG};

  function automatic logic [31:0] mk(input logic st, input logic clr, input logic ie,
                                     input logic rt, input logic [1:0] ts, input logic [4:0] n,
                                     input logic [4:0] fw, input logic [4:0] sy);
    return {st, clr, clr, clr, ie, rt, ts, 3'b000, n, 6'b000000, fw, sy};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_tx(input int base, input int n);
    for (int k = 0; k < 2000 && (txn - base) < n; k++) @(negedge clk);
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd(3'd0, v);
    while (v[31] && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      rd(3'd0, v);
    end
  endtask

  task automatic rx_send(input int n, input int err_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hA0 + 8'(i);
      rx_sop = (i == 0); rx_eop = (i == n - 1); rx_err = (i == err_at);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got expired expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] w0, w1, w4;
    int base, cyc;
    w0 = {4'h9, 4'h1, 8'h23, 8'h45, 8'h03};
    w1 = 32'h55667788;
    w4 = 32'h01020304;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(3'd0, v); chk("R11 ctl", v, 32'h0);
    rd(3'd2, v); chk("R11 data", v, 32'h0);
    chk("R9 irq reset", {31'b0, irq}, 32'h0);
    chk("R10 sync reset", {26'b0, sync_pulses}, 32'd1);

    // R10 configuration
    wr(3'd0, mk(0, 0, 1, 1, 2'd1, 5'd0, 5'd7, 5'd5));
    rd(3'd0, v); chk("R1 ctl readback", v, mk(0, 0, 1, 1, 2'd1, 5'd0, 5'd7, 5'd5));
    chk("R10 sync", {26'b0, sync_pulses}, 32'd6);
    chk("R10 fast wake", {26'b0, fw_sync_pulses}, 32'd8);
    chk("R10 route", {31'b0, route_sel}, 32'd1);

    wr(3'd1, w0); wr(3'd2, w1); wr(3'd5, w4);

    // R1 R2 R3: stalled transmit, writes during busy
    tx_ready = 1'b0;
    base = txn;
    wr(3'd0, mk(1, 1, 1, 1, 2'd1, 5'd8, 5'd7, 5'd5));
    repeat (2) @(negedge clk);
    chk("R2 first byte held", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'h91});
    wr(3'd0, mk(0, 1, 0, 0, 2'd2, 5'd4, 5'd0, 5'd0));
    wr(3'd2, 32'hDEADBEEF);
    rd(3'd0, v); chk("R3 ctl frozen", v, mk(1, 0, 1, 1, 2'd1, 5'd8, 5'd7, 5'd5));
    rd(3'd2, v); chk("R3 data frozen", v, w1);
    tx_ready = 1'b1;
    wait_tx(base, 8);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = (i < 4) ? w0 : w1;
      chk("R2 tx byte", {24'b0, txb[base + i]}, {24'b0, w[31 - 8 * (i % 4) -: 8]});
      chk("R1 tx markers", {30'b0, txs[base + i], txe[base + i]},
          {30'b0, (i == 0) ? 1'b1 : 1'b0, (i == 7) ? 1'b1 : 1'b0});
    end

    // R6 reply capture
    rx_send(5, -1);
    wait_idle(cyc);
    rd(3'd0, v); chk("R6 R4 reply status", v, mk(0, 0, 1, 1, 2'd1, 5'd5, 5'd7, 5'd5) | 32'h4000_0000);
    rd(3'd1, v); chk("R6 word0", v, 32'hA0A1A2A3);
    rd(3'd2, v); chk("R6 word1 partial", v, 32'hA4667788);
    chk("R9 irq on done", {31'b0, irq}, 32'd1);

    // R4 write-1-to-clear
    wr(3'd0, mk(0, 1, 1, 1, 2'd1, 5'd0, 5'd7, 5'd5));
    rd(3'd0, v); chk("R4 done cleared", v, mk(0, 0, 1, 1, 2'd1, 5'd0, 5'd7, 5'd5));
    chk("R9 irq cleared", {31'b0, irq}, 32'd0);

    // R7 overlong reply
    base = txn;
    wr(3'd0, mk(1, 1, 1, 1, 2'd1, 5'd4, 5'd7, 5'd5));
    wait_tx(base, 4);
    rx_send(19, -1);
    wait_idle(cyc);
    rd(3'd0, v); chk("R7 overflow status", v, mk(0, 0, 1, 1, 2'd1, 5'd17, 5'd7, 5'd5) | 32'h5000_0000);
    rd(3'd5, v); chk("R7 last stored byte", v, 32'hB0020304);

    // R8 receive error
    base = txn;
    wr(3'd0, mk(1, 1, 1, 1, 2'd1, 5'd4, 5'd7, 5'd5));
    wait_tx(base, 4);
    rx_send(2, 1);
    wait_idle(cyc);
    rd(3'd0, v); chk("R8 rx error status", v, mk(0, 0, 1, 1, 2'd1, 5'd2, 5'd7, 5'd5) | 32'h5000_0000);

    // R5 timeout table
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, mk(1, 1, 0, 0, T_SEL[i], 5'd4, 5'd7, 5'd5));
      wait_idle(cyc);
      chk("R5 timeout window",
          {31'b0, (cyc >= T_US[i] * P) && (cyc <= T_US[i] * P + 7)}, 32'd1);
      rd(3'd0, v); chk("R5 timeout status", v, mk(0, 0, 0, 0, T_SEL[i], 5'd0, 5'd7, 5'd5) | 32'h6000_0000);
      chk("R9 irq disabled", {31'b0, irq}, 32'd0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule